// File: doc/BRIEF.md
# Dual-Compare Pulse Train Generator

This block is a timer slice that produces a periodic pulse on a single output pin without any software handling of the edges. A free-running 16-bit up-counter advances on ticks from a power-of-two prescaler. Two compare channels watch the counter. The master channel, when its match occurs, forces the pin to a programmed level through a mask bit. The secondary channel, on its own match, applies a set, clear or toggle action. Programming one channel to raise the pin and the other to drop it yields a pulse whose width and period follow from the two compare values.

Each channel has a sticky match flag. Writing 1 to a flag bit clears it. An interrupt line is raised while any enabled flag is set. Software loads every control field through a simple single-cycle write port. A write takes effect on the clock edge that samples it. The asynchronous active-low reset is released through a two-stage synchronizer, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `pulse_train_timer`

## Requirements
- R1: The 16-bit counter holds its value while the run bit (bit 0 of register 0) is 0. It advances while that bit is 1.
- R2: The prescaler code in bits 3:1 of register 0 makes the counter advance once every 2^code clock cycles. Code 0 advances it on every cycle, and code 2 once every 4 cycles.
- R3: A match occurs when the counter steps onto a compare value. On the same clock edge that the counter takes that value, a master match sets flag bit 0 and a secondary match sets flag bit 1.
- R4: On a secondary match the pin follows the 2-bit action in register 4: 00 leaves it unchanged, 01 toggles it, 10 drives it low and 11 drives it high.
- R5: On a master match with the force mask (register 3 bit 0) at 1, the pin takes the force level (register 3 bit 1). With the mask at 0, the master match leaves the pin unchanged and still sets its flag.
- R6: When both channels match on the same tick and the force mask is 1, the force level wins over the secondary action.
- R7: Writing to register 6 clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R8: The interrupt output is high exactly while some flag is set whose enable bit in register 5 is 1. Bit 0 enables the master flag and bit 1 the secondary flag.
- R9: The compare values (register 1 master, register 2 secondary) may be rewritten while the counter runs. Only the new value is used for later matches.
- R10: After reset the counter is 0, the pin is low, both flags are clear and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select (0..6) |
| wr_data | input | 16 | Write data |
| count_o | output | 16 | Current counter value |
| pin_o | output | 1 | Generated pulse output |
| flag_o | output | 2 | Match flags: bit 0 master, bit 1 secondary |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and a 3-bit prescaler code. That makes divide ratios from 1 to 128 reachable. The bench measures codes 0, 2 and 3 over windows that are whole multiples of the division, so the tick count in each window is exact. Compare values are set relative to the stopped counter. This puts each match a few ticks ahead and keeps every pin action, priority case and compare rewrite within a few dozen cycles. Counter wrap-around is covered by an assertion on the step size.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_TOG  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_SET  = 2'b11
  } act_e;

  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_CMP_M = 3'd1;
  localparam logic [2:0] REG_CMP_S = 3'd2;
  localparam logic [2:0] REG_FORCE = 3'd3;
  localparam logic [2:0] REG_ACT   = 3'd4;
  localparam logic [2:0] REG_IEN   = 3'd5;
  localparam logic [2:0] REG_CLR   = 3'd6;

  localparam int NUM_CH = 2;
  localparam int CH_M   = 0;
  localparam int CH_S   = 1;
endpackage

// File: rtl/pt_timebase.sv
module pt_timebase #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] code,
  output logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_inc
);
  localparam int DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] pre_q, pre_d, msk;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    msk     = (DIV_W'(1) << code) - DIV_W'(1);
    tick    = run && ((pre_q & msk) == msk);
    pre_d   = run ? pre_q + DIV_W'(1) : pre_q;
    cnt_inc = cnt_q + CNT_W'(1);
    cnt_d   = tick ? cnt_inc : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  a_r1_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q));
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/pt_compare.sv
module pt_compare #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_inc,
  input  logic [CNT_W-1:0] cmp,
  input  logic [CNT_W-1:0] cnt_q,
  output logic             hit
);
  assign hit = tick && (cnt_inc == cmp);

  // R3: after a hit the counter holds the value that was compared
  a_r3_hit_lands: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt_q == $past(cmp)));
endmodule

// File: rtl/pt_pin.sv
module pt_pin (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_m,
  input  logic          hit_s,
  input  pt_pkg::act_e  act,
  input  logic          frc_mask,
  input  logic          frc_level,
  output logic          pin_q
);
  import pt_pkg::*;
  logic pin_d;

  always_comb begin
    pin_d = pin_q;
    if (hit_s) begin
      case (act)
        ACT_TOG: pin_d = ~pin_q;
        ACT_CLR: pin_d = 1'b0;
        ACT_SET: pin_d = 1'b1;
        default: pin_d = pin_q;
      endcase
    end
    if (hit_m && frc_mask) pin_d = frc_level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  a_r4_quiet_without_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_m && !hit_s) |=> $stable(pin_q));
  a_r6_force_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_m && frc_mask) |=> (pin_q == $past(frc_level)));
endmodule

// File: rtl/pt_flags.sv
module pt_flags #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set,
  input  logic [NCH-1:0] clr,
  input  logic [NCH-1:0] ien,
  output logic [NCH-1:0] flag_q,
  output logic           irq
);
  logic [NCH-1:0] flag_d;

  always_comb flag_d = (flag_q & ~clr) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign irq = |(flag_q & ien);

  a_r3_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((flag_q & $past(set)) == $past(set)));
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flag_q) & ~$past(clr)) & ~flag_q) == '0));
endmodule

// File: rtl/pulse_train_timer.sv
module pulse_train_timer #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_o,
  output logic             pin_o,
  output logic [1:0]       flag_o,
  output logic             irq_o
);
  import pt_pkg::*;

  logic [1:0] rs_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  logic             run_q, run_d;
  logic [PSC_W-1:0] psc_q, psc_d;
  logic [CNT_W-1:0] cmp_q [NUM_CH];
  logic [CNT_W-1:0] cmp_d [NUM_CH];
  logic [1:0]       frc_q, frc_d, act_q, act_d, ien_q, ien_d, clr_w1;

  always_comb begin
    run_d  = run_q;
    psc_d  = psc_q;
    cmp_d  = cmp_q;
    frc_d  = frc_q;
    act_d  = act_q;
    ien_d  = ien_q;
    clr_w1 = 2'b00;
    if (wr_en) begin
      case (wr_addr)
        REG_CTRL:  begin run_d = wr_data[0]; psc_d = wr_data[PSC_W:1]; end
        REG_CMP_M: cmp_d[CH_M] = wr_data;
        REG_CMP_S: cmp_d[CH_S] = wr_data;
        REG_FORCE: frc_d = wr_data[1:0];
        REG_ACT:   act_d = wr_data[1:0];
        REG_IEN:   ien_d = wr_data[1:0];
        REG_CLR:   clr_w1 = wr_data[1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      run_q <= 1'b0;
      psc_q <= '0;
      cmp_q <= '{default: '0};
      frc_q <= 2'b00;
      act_q <= 2'b00;
      ien_q <= 2'b00;
    end else begin
      run_q <= run_d;
      psc_q <= psc_d;
      cmp_q <= cmp_d;
      frc_q <= frc_d;
      act_q <= act_d;
      ien_q <= ien_d;
    end
  end

  logic             tick;
  logic [CNT_W-1:0] cnt_inc;
  logic [NUM_CH-1:0] hit;

  pt_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
    .clk(clk), .rst_n(rst_s), .run(run_q), .code(psc_q),
    .tick(tick), .cnt_q(count_o), .cnt_inc(cnt_inc)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    pt_compare #(.CNT_W(CNT_W)) u_cmp (
      .clk(clk), .rst_n(rst_s), .tick(tick), .cnt_inc(cnt_inc),
      .cmp(cmp_q[ch]), .cnt_q(count_o), .hit(hit[ch])
    );
  end

  pt_pin u_pin (
    .clk(clk), .rst_n(rst_s), .hit_m(hit[CH_M]), .hit_s(hit[CH_S]),
    .act(act_e'(act_q)), .frc_mask(frc_q[0]), .frc_level(frc_q[1]),
    .pin_q(pin_o)
  );

  pt_flags #(.NCH(NUM_CH)) u_flg (
    .clk(clk), .rst_n(rst_s), .set(hit), .clr(clr_w1), .ien(ien_q),
    .flag_q(flag_o), .irq(irq_o)
  );

  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_s)
    (flag_o == 2'b00) |-> !irq_o);
endmodule

// File: tb/tb_pulse_train_timer.sv
module tb_pulse_train_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [15:0] count_o;
  logic        pin_o;
  logic [1:0]  flag_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pulse_train_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count_o(count_o), .pin_o(pin_o),
    .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic stop_timer();
    wr(3'd0, 16'h0000);
    @(negedge clk);
  endtask

  task automatic go(input logic [2:0] code);
    wr(3'd0, {12'h000, code, 1'b1});
  endtask

  // stop, clear flags, program channels relative to the held count
  task automatic arm(input logic [15:0] m_off, input logic [15:0] s_off,
                     input logic [1:0] frc, input logic [1:0] act,
                     output logic [15:0] base);
    stop_timer();
    base = count_o;
    wr(3'd1, base + m_off);
    wr(3'd2, base + s_off);
    wr(3'd3, {14'h0, frc});
    wr(3'd4, {14'h0, act});
    wr(3'd6, 16'h0003);
  endtask

  task automatic wait_count(input logic [15:0] v);
    for (int i = 0; i < 2000 && count_o != v; i++) @(negedge clk);
  endtask

  task automatic run_match(input logic [15:0] m_off, input logic [15:0] s_off,
                           input logic [1:0] frc, input logic [1:0] act);
    logic [15:0] b;
    arm(m_off, s_off, frc, act, b);
    go(3'd0);
    repeat (10) @(negedge clk);
    stop_timer();
  endtask

  task automatic t_reset();
    chk("R10 count", count_o, 0);
    chk("R10 pin", pin_o, 0);
    chk("R10 flags", flag_o, 0);
    chk("R10 irq", irq_o, 0);
  endtask

  task automatic t_counting();
    logic [15:0] a;
    a = count_o;
    repeat (12) @(negedge clk);
    chk("R1 held while stopped", count_o, a);
    go(3'd0);
    a = count_o;
    repeat (20) @(negedge clk);
    chk("R1 R2 code0 advance", 16'(count_o - a), 20);
    go(3'd2);
    a = count_o;
    repeat (40) @(negedge clk);
    chk("R2 code2 advance", 16'(count_o - a), 10);
    go(3'd3);
    a = count_o;
    repeat (64) @(negedge clk);
    chk("R2 code3 advance", 16'(count_o - a), 8);
    stop_timer();
    a = count_o;
    repeat (20) @(negedge clk);
    chk("R1 held after stop", count_o, a);
  endtask

  task automatic t_match_edge();
    logic [15:0] b;
    logic prev;
    arm(16'hFFFF, 16'd3, 2'b00, 2'b00, b);
    go(3'd0);
    prev = flag_o[1];
    for (int i = 0; i < 50 && count_o != 16'(b + 3); i++) begin
      prev = flag_o[1];
      @(negedge clk);
    end
    chk("R3 flag low before match", prev, 0);
    chk("R3 flag with count", flag_o[1], 1);
    chk("R3 master flag idle", flag_o[0], 0);
    stop_timer();
    chk("R4 action none keeps pin", pin_o, 0);
  endtask

  task automatic t_actions();
    run_match(16'hFFFF, 16'd3, 2'b00, 2'b11);
    chk("R4 set", pin_o, 1);
    run_match(16'hFFFF, 16'd3, 2'b00, 2'b01);
    chk("R4 toggle to low", pin_o, 0);
    run_match(16'hFFFF, 16'd3, 2'b00, 2'b01);
    chk("R4 toggle to high", pin_o, 1);
    run_match(16'hFFFF, 16'd3, 2'b00, 2'b10);
    chk("R4 clear", pin_o, 0);
  endtask

  task automatic t_master();
    run_match(16'd3, 16'hFFFF, 2'b11, 2'b00);
    chk("R5 force high", pin_o, 1);
    chk("R3 master flag", flag_o, 1);
    run_match(16'd3, 16'hFFFF, 2'b00, 2'b00);
    chk("R5 mask off keeps pin", pin_o, 1);
    chk("R5 mask off flag", flag_o, 1);
    run_match(16'd3, 16'hFFFF, 2'b01, 2'b00);
    chk("R5 force low", pin_o, 0);
  endtask

  task automatic t_priority();
    run_match(16'd4, 16'd4, 2'b01, 2'b11);
    chk("R6 force low beats set", pin_o, 0);
    chk("R6 both flags", flag_o, 3);
    run_match(16'd4, 16'd4, 2'b11, 2'b10);
    chk("R6 force high beats clear", pin_o, 1);
    run_match(16'd4, 16'd4, 2'b01, 2'b01);
    chk("R6 force low beats toggle", pin_o, 0);
  endtask

  task automatic t_pulse();
    logic [15:0] b;
    arm(16'd6, 16'd3, 2'b01, 2'b11, b);
    go(3'd0);
    wait_count(16'(b + 4));
    chk("R4 pulse high", pin_o, 1);
    wait_count(16'(b + 7));
    chk("R5 pulse low", pin_o, 0);
    stop_timer();
  endtask

  task automatic t_flags_irq();
    run_match(16'd4, 16'd5, 2'b00, 2'b00);
    chk("R3 both flags", flag_o, 3);
    chk("R8 disabled irq", irq_o, 0);
    wr(3'd6, 16'h0000);
    chk("R7 zero write", flag_o, 3);
    wr(3'd5, 16'h0002);
    chk("R8 enabled irq", irq_o, 1);
    wr(3'd6, 16'h0001);
    chk("R7 clear bit0", flag_o, 2);
    wr(3'd5, 16'h0001);
    chk("R8 other enable", irq_o, 0);
    wr(3'd6, 16'h0002);
    chk("R7 clear bit1", flag_o, 0);
    wr(3'd5, 16'h0000);
  endtask

  task automatic t_rewrite();
    logic [15:0] b;
    arm(16'hFFFF, 16'd5, 2'b00, 2'b11, b);
    go(3'd0);
    wait_count(16'(b + 2));
    wr(3'd2, b + 16'd10);
    wait_count(16'(b + 7));
    chk("R9 old value ignored", flag_o[1], 0);
    chk("R9 pin untouched", pin_o, 0);
    wait_count(16'(b + 11));
    chk("R9 new value used", flag_o[1], 1);
    chk("R9 pin set", pin_o, 1);
    stop_timer();
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_counting();
    t_match_edge();
    t_actions();
    t_master();
    t_priority();
    t_pulse();
    t_flags_irq();
    t_rewrite();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule